// File: doc/BRIEF.md
# Clock Mode Control Register

This block is the 8-bit control register that sits in front of a clock generator. A host reaches it through a plain register port: an address-decode hit, a write strobe, write data and combinational read data. The register stores the oscillator gain choice, the frequency range, the reference type, the requested clock mode, the off-mode oscillator policy and the loss-of-clock detection disable. It returns these values on a read, and bit 0 always reads as zero.

The register also enforces the access rules of the clock generator:
- The range and reference fields accept only the first write after reset.
- A first write that requests an internal-only mode permanently rules out the external-reference modes until the next reset.
- A mode request stays pending until the clock switching logic reports completion. While it is pending, later mode writes are dropped.

From the stored fields the block derives three things: the selected mode, the loop prescale factor, and whether the oscillator must keep running. The oscillator, the loop and the switching circuits are outside the block. Their status reaches it as plain inputs.

The register port has no back-pressure. Every write strobe is taken in the cycle it is presented, and reads need no wait cycle. Because the port carries no data stream, it uses no valid/ready handshake.

Top module: `clkgen_mode_reg`

## Requirements
- R1: After reset the read value is 0x44, `sel_mode` is 00, `mode_pending` is 0, `loop_prescale` is 1 and `lossclk_det_en` is 1.
- R2: Every write updates bit 7 (gain: 1 is high amplitude, shown on `osc_high_gain`), bit 2 (off-mode oscillator policy) and bit 1 (1 disables loss-of-clock detection, so `lossclk_det_en` is its inverse). Bit 0 reads 0 whatever is written.
- R3: Bit 6 (range) takes the first write after reset, even one that writes the same value, and ignores all later writes. `loop_prescale` is 64 when bit 6 is 0 and 1 when bit 6 is 1.
- R4: Bit 5 (reference type) has its own lock flag and follows the same write-once rule as bit 6.
- R5: If bits 4:3 of the first write after reset are 0X, any later write that sets bit 4 leaves bits 4:3 unchanged until the next reset. Bits 4:3 encode the mode as follows: 00 self-clocked, 01 loop with internal reference, 10 loop bypassed with external reference, 11 loop with external reference.
- R6: An accepted write of bits 4:3 raises `mode_pending`. While `mode_pending` is 1, writes leave bits 4:3 unchanged.
- R7: For stored modes 00, 01 and 11, a one-cycle `switch_done` pulse while pending copies the stored mode to `sel_mode` and clears `mode_pending` at the next edge. `sel_mode` changes at no other time.
- R8: For stored mode 10, `sel_mode` and `mode_pending` update only at an edge where `switch_done` and `ref_ready` are both 1.
- R9: Outside off mode, `osc_run` equals stored bit 4. In off mode, with bit 2 set, `osc_run` = bit 4 AND `ref_is_osc`. With bit 2 clear, `osc_run` = `osc_keep_req` AND (bits 4:3 == 10) AND `ref_is_osc`.
- R10: Entering or staying in off mode leaves the stored bits 4:3 unchanged.
- R11: `bus_rdata` is 0 whenever `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Address decode hit for this register |
| bus_wr | input | 1 | Write strobe, taken when bus_sel is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not selected |
| switch_done | input | 1 | One-cycle pulse: clock switch finished |
| ref_ready | input | 1 | External reference is ready |
| ref_is_osc | input | 1 | Reference status: oscillator reference in use |
| off_mode | input | 1 | Clock generator is in off mode |
| osc_keep_req | input | 1 | Request to keep the oscillator alive in off mode |
| sel_mode | output | 2 | Mode currently selected |
| mode_pending | output | 1 | A mode request awaits completion |
| loop_prescale | output | 7 | Loop prescale factor (64 or 1) |
| osc_run | output | 1 | Oscillator must run |
| osc_high_gain | output | 1 | High-amplitude oscillator operation |
| lossclk_det_en | output | 1 | Loss-of-clock detection enabled |

## Verification
The hardest states to reach from the ports are those that depend on what the very first write after reset carried: the permanent block on external modes, and the fixed range and reference fields. The stimulus therefore applies reset twice. It opens one run with an internal-mode write and the other with a bypass-mode write. The second run then holds a bypass request pending through a completion pulse that arrives without `ref_ready`. A randomized phase follows, with writes landing while a request is pending, and a behavioural model is compared against the design on every clock.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int REG_W      = 8;
  localparam int POS_GAIN   = 7;
  localparam int POS_RANGE  = 6;
  localparam int POS_REFSEL = 5;
  localparam int POS_MODE_H = 4;
  localparam int POS_MODE_L = 3;
  localparam int POS_OFFOSC = 2;
  localparam int POS_LOCDIS = 1;
  localparam logic [REG_W-1:0] RESET_VALUE = 8'h44;

  typedef enum logic [1:0] {
    MODE_SELF       = 2'b00,
    MODE_INT_LOOP   = 2'b01,
    MODE_EXT_BYPASS = 2'b10,
    MODE_EXT_LOOP   = 2'b11
  } clk_mode_e;

  typedef struct packed {
    logic      gain;
    logic      range;
    logic      refsel;
    clk_mode_e mode;
    logic      offosc;
    logic      locdis;
    logic      unused0;
  } cfg_t;
endpackage

// File: rtl/cmr_once_field.sv
module cmr_once_field #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= RST_VAL;
      locked <= 1'b0;
    end else if (wr) begin
      locked <= 1'b1;
      if (!locked) q <= wdata;
    end
  end
endmodule

// File: rtl/cmr_mode_ctl.sv
module cmr_mode_ctl
  import clkmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  clk_mode_e wmode,
  input  logic      switch_done,
  input  logic      ref_ready,
  output clk_mode_e mode_q,
  output clk_mode_e sel_q,
  output logic      pending,
  output logic      ext_block
);
  logic first_seen;
  logic accept;
  logic complete;

  // an external-mode write is refused once the first write chose internal
  assign accept   = wr && !pending && !(ext_block && wmode[1]);
  assign complete = pending && switch_done &&
                    ((mode_q != MODE_EXT_BYPASS) || ref_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
      ext_block  <= 1'b0;
    end else if (wr && !first_seen) begin
      first_seen <= 1'b1;
      ext_block  <= !wmode[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SELF;
      sel_q   <= MODE_SELF;
      pending <= 1'b0;
    end else if (accept) begin
      mode_q  <= wmode;
      pending <= 1'b1;
    end else if (complete) begin
      sel_q   <= mode_q;
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cmr_status.sv
module cmr_status
  import clkmode_pkg::*;
#(
  parameter int PS_W        = 7,
  parameter int LOW_FACTOR  = 64,
  parameter int HIGH_FACTOR = 1
) (
  input  logic            range_hi,
  input  clk_mode_e       mode_q,
  input  logic            offosc,
  input  logic            off_mode,
  input  logic            ref_is_osc,
  input  logic            osc_keep_req,
  output logic [PS_W-1:0] prescale,
  output logic            osc_run
);
  always_comb begin
    prescale = range_hi ? PS_W'(HIGH_FACTOR) : PS_W'(LOW_FACTOR);
    if (!off_mode) begin
      osc_run = mode_q[1];
    end else if (offosc) begin
      osc_run = mode_q[1] && ref_is_osc;
    end else begin
      osc_run = osc_keep_req && (mode_q == MODE_EXT_BYPASS) && ref_is_osc;
    end
  end
endmodule

// File: rtl/clkgen_mode_reg.sv
module clkgen_mode_reg
  import clkmode_pkg::*;
#(
  parameter int PS_W        = 7,
  parameter int LOW_FACTOR  = 64,
  parameter int HIGH_FACTOR = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            switch_done,
  input  logic            ref_ready,
  input  logic            ref_is_osc,
  input  logic            off_mode,
  input  logic            osc_keep_req,
  output logic [1:0]      sel_mode,
  output logic            mode_pending,
  output logic [PS_W-1:0] loop_prescale,
  output logic            osc_run,
  output logic            osc_high_gain,
  output logic            lossclk_det_en
);
  cfg_t      rst_cfg;
  cfg_t      wcfg;
  cfg_t      cur;
  logic      wr_hit;
  logic      gain_q, offosc_q, locdis_q;
  logic      range_q, range_lock;
  logic      refsel_q, refsel_lock;
  clk_mode_e mode_q, sel_q;
  logic      ext_block;

  assign rst_cfg = cfg_t'(RESET_VALUE);
  assign wcfg    = cfg_t'(bus_wdata);
  assign wr_hit  = bus_sel && bus_wr;

  // fields that take every write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q   <= RESET_VALUE[POS_GAIN];
      offosc_q <= RESET_VALUE[POS_OFFOSC];
      locdis_q <= RESET_VALUE[POS_LOCDIS];
    end else if (wr_hit) begin
      gain_q   <= wcfg.gain;
      offosc_q <= wcfg.offosc;
      locdis_q <= wcfg.locdis;
    end
  end

  cmr_once_field #(.W(1), .RST_VAL(RESET_VALUE[POS_RANGE])) u_range (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit), .wdata(wcfg.range),
    .q(range_q), .locked(range_lock));

  cmr_once_field #(.W(1), .RST_VAL(RESET_VALUE[POS_REFSEL])) u_refsel (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit), .wdata(wcfg.refsel),
    .q(refsel_q), .locked(refsel_lock));

  cmr_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit), .wmode(wcfg.mode),
    .switch_done(switch_done), .ref_ready(ref_ready),
    .mode_q(mode_q), .sel_q(sel_q), .pending(mode_pending),
    .ext_block(ext_block));

  cmr_status #(.PS_W(PS_W), .LOW_FACTOR(LOW_FACTOR), .HIGH_FACTOR(HIGH_FACTOR)) u_stat (
    .range_hi(range_q), .mode_q(mode_q), .offosc(offosc_q),
    .off_mode(off_mode), .ref_is_osc(ref_is_osc), .osc_keep_req(osc_keep_req),
    .prescale(loop_prescale), .osc_run(osc_run));

  always_comb begin
    cur         = rst_cfg;
    cur.gain    = gain_q;
    cur.range   = range_q;
    cur.refsel  = refsel_q;
    cur.mode    = mode_q;
    cur.offosc  = offosc_q;
    cur.locdis  = locdis_q;
    cur.unused0 = 1'b0;
    bus_rdata   = bus_sel ? 8'(cur) : 8'h00;
  end

  assign sel_mode       = sel_q;
  assign osc_high_gain  = gain_q;
  assign lossclk_det_en = !locdis_q;
endmodule

// File: rtl/clkgen_mode_reg_chk.sv
module clkgen_mode_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic       switch_done,
  input logic       ref_ready,
  input logic       off_mode,
  input logic [1:0] mode_q,
  input logic [1:0] sel_mode,
  input logic       mode_pending,
  input logic       ext_block,
  input logic       range_q,
  input logic       range_lock
);
  AST_RANGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    range_lock |=> $stable(range_q)); // R3

  AST_EXT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_block |-> !mode_q[1]); // R5

  AST_PENDING_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pending && wr_hit) |=> $stable(mode_q)); // R6

  AST_SEL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode != $past(sel_mode)) |-> $past(switch_done && mode_pending)); // R7

  AST_BYPASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode == 2'b10 && $past(sel_mode) != 2'b10) |-> $past(ref_ready)); // R8

  AST_OFF_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (off_mode && !wr_hit) |=> $stable(mode_q)); // R10
endmodule

bind clkgen_mode_reg clkgen_mode_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .switch_done(switch_done),
  .ref_ready(ref_ready), .off_mode(off_mode), .mode_q(mode_q),
  .sel_mode(sel_mode), .mode_pending(mode_pending), .ext_block(ext_block),
  .range_q(range_q), .range_lock(range_lock));

// File: tb/clkgen_mode_reg_bench.sv
module clkgen_mode_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       switch_done = 1'b0, ref_ready = 1'b0, ref_is_osc = 1'b0;
  logic       off_mode = 1'b0, osc_keep_req = 1'b0;
  logic [1:0] sel_mode;
  logic       mode_pending;
  logic [6:0] loop_prescale;
  logic       osc_run, osc_high_gain, lossclk_det_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  clkgen_mode_reg u_clkgen_mode_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .switch_done(switch_done),
    .ref_ready(ref_ready), .ref_is_osc(ref_is_osc), .off_mode(off_mode),
    .osc_keep_req(osc_keep_req), .sel_mode(sel_mode), .mode_pending(mode_pending),
    .loop_prescale(loop_prescale), .osc_run(osc_run),
    .osc_high_gain(osc_high_gain), .lossclk_det_en(lossclk_det_en));

  // behavioural reference model
  int m_gain, m_range, m_ref, m_mode, m_offosc, m_locdis;
  int m_rlock, m_flock, m_seen, m_block, m_pend, m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gain = 0; m_range = 1; m_ref = 0; m_mode = 0; m_offosc = 1; m_locdis = 0;
      m_rlock = 0; m_flock = 0; m_seen = 0; m_block = 0; m_pend = 0; m_sel = 0;
      started = 1;
    end else begin
      int old_pend;
      old_pend = m_pend;
      if (m_pend == 1 && switch_done && (m_mode != 2 || ref_ready)) begin
        m_sel = m_mode;
        m_pend = 0;
      end
      if (bus_sel && bus_wr) begin
        m_gain = bus_wdata[7];
        if (m_rlock == 0) m_range = bus_wdata[6];
        m_rlock = 1;
        if (m_flock == 0) m_ref = bus_wdata[5];
        m_flock = 1;
        if (old_pend == 0 && !(m_block == 1 && bus_wdata[4])) begin
          m_mode = bus_wdata[4:3];
          m_pend = 1;
        end
        if (m_seen == 0) begin
          m_seen = 1;
          if (!bus_wdata[4]) m_block = 1;
        end
        m_offosc = bus_wdata[2];
        m_locdis = bus_wdata[1];
      end
    end
  end

  function automatic int model_rdata();
    if (!bus_sel) return 0;
    return (m_gain << 7) | (m_range << 6) | (m_ref << 5) | (m_mode << 3) |
           (m_offosc << 2) | (m_locdis << 1);
  endfunction

  function automatic int model_osc();
    if (!off_mode) return (m_mode >> 1) & 1;
    if (m_offosc == 1) return ((m_mode >> 1) & 1) & int'(ref_is_osc);
    return int'(osc_keep_req && m_mode == 2 && ref_is_osc);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk) begin
    if (started && rst_n && !finished) begin
      chk("R2/R11 rdata model", int'(bus_rdata), model_rdata());
      chk("R7 sel_mode model", int'(sel_mode), m_sel);
      chk("R6 pending model", int'(mode_pending), m_pend);
      chk("R3 prescale model", int'(loop_prescale), (m_range == 1) ? 1 : 64);
      chk("R9 osc_run model", int'(osc_run), model_osc());
      chk("R2 gain model", int'(osc_high_gain), m_gain);
      chk("R2 lossclk model", int'(lossclk_det_en), 1 - m_locdis);
    end
  end

  task automatic wr_reg(input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int exp);
    bus_sel = 1'b1; #1;
    chk(tag, int'(bus_rdata), exp);
    bus_sel = 1'b0; #1;
  endtask

  task automatic done_pulse(input logic rdy);
    @(posedge clk); #1;
    switch_done = 1'b1; ref_ready = rdy;
    @(posedge clk); #1;
    switch_done = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; #1;
    // R1 reset state
    rd_chk("R1 reset value", 8'h44);
    chk("R1 sel after reset", int'(sel_mode), 0);
    chk("R1 pending after reset", int'(mode_pending), 0);
    chk("R1 prescale after reset", int'(loop_prescale), 1);
    chk("R1 lossclk after reset", int'(lossclk_det_en), 1);
    // R11: not selected reads zero
    chk("R11 rdata idle", int'(bus_rdata), 0);

    // first write: internal loop, range 0, loss detect disabled, bit0 set
    wr_reg(8'h0B);
    rd_chk("R2 bit0 reads zero", 8'h0A);
    chk("R2 lossclk disabled", int'(lossclk_det_en), 0);
    chk("R3 prescale low range", int'(loop_prescale), 64);
    chk("R6 pending raised", int'(mode_pending), 1);
    chk("R7 sel unchanged before done", int'(sel_mode), 0);
    // write while pending: mode, range, ref ignored; gain applied
    wr_reg(8'hF8);
    rd_chk("R6 write while pending", 8'h88);
    chk("R2 high gain", int'(osc_high_gain), 1);
    done_pulse(1'b0);
    chk("R7 sel follows done", int'(sel_mode), 1);
    chk("R7 pending cleared", int'(mode_pending), 0);
    // external mode after internal first write is refused
    wr_reg(8'h18);
    rd_chk("R5 external mode refused", 8'h08);
    chk("R5 no pending on refusal", int'(mode_pending), 0);
    wr_reg(8'h00);
    done_pulse(1'b0);
    chk("R7 back to self-clocked", int'(sel_mode), 0);
    // off mode, policy bit clear, mode 00
    off_mode = 1'b1; osc_keep_req = 1'b1; ref_is_osc = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R9 off, mode 00", int'(osc_run), 0);
    rd_chk("R10 mode kept in off mode", 8'h00);
    off_mode = 1'b0; osc_keep_req = 1'b0; ref_is_osc = 1'b0;

    // second run: first write requests bypass external
    do_reset();
    wr_reg(8'h74);
    rd_chk("R5 bypass accepted first", 8'h74);
    done_pulse(1'b0);
    chk("R8 bypass waits for ready", int'(sel_mode), 0);
    chk("R8 still pending", int'(mode_pending), 1);
    done_pulse(1'b1);
    chk("R8 bypass selected", int'(sel_mode), 2);
    chk("R8 pending cleared", int'(mode_pending), 0);
    wr_reg(8'h34);
    rd_chk("R3 range locked", 8'h74);
    chk("R3 prescale high range", int'(loop_prescale), 1);
    done_pulse(1'b1);
    wr_reg(8'h54);
    rd_chk("R4 reference locked", 8'h74);
    done_pulse(1'b1);
    // off-mode oscillator policy
    off_mode = 1'b1; ref_is_osc = 1'b1; osc_keep_req = 1'b0; #1;
    chk("R9 policy set, osc ref", int'(osc_run), 1);
    ref_is_osc = 1'b0; #1;
    chk("R9 policy set, no osc ref", int'(osc_run), 0);
    wr_reg(8'h70);
    done_pulse(1'b1);
    ref_is_osc = 1'b1; osc_keep_req = 1'b1; #1;
    chk("R9 policy clear, keep req", int'(osc_run), 1);
    osc_keep_req = 1'b0; #1;
    chk("R9 policy clear, no keep req", int'(osc_run), 0);
    wr_reg(8'h78);
    done_pulse(1'b1);
    osc_keep_req = 1'b1; #1;
    chk("R9 policy clear, mode 11", int'(osc_run), 0);
    rd_chk("R10 stored mode in off mode", 8'h78);
    off_mode = 1'b0; #1;
    chk("R9 run outside off mode", int'(osc_run), 1);

    // randomized phase, checked by the model every clock
    for (int k = 0; k < 2; k++) begin
      do_reset();
      for (int i = 0; i < 400; i++) begin
        @(posedge clk); #1;
        bus_sel      = ($urandom_range(0, 3) != 0);
        bus_wr       = ($urandom_range(0, 4) == 0);
        bus_wdata    = 8'($urandom);
        switch_done  = ($urandom_range(0, 5) == 0);
        ref_ready    = ($urandom_range(0, 2) != 0);
        ref_is_osc   = ($urandom_range(0, 1) != 0);
        off_mode     = ($urandom_range(0, 3) == 0);
        osc_keep_req = ($urandom_range(0, 1) != 0);
      end
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; switch_done = 1'b0;
    end
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule